// File: doc/BRIEF.md
# Trip-Count Age Replacement for an Exclusive Cache Set

This block holds the replacement state for one set of an exclusive last-level cache that serves as a victim store for the cache above it. In an exclusive cache a hit moves the line upward and removes it here, so recency of use never builds up. Instead, each line gets an age when it is written in, and that age depends on one trip-count bit. The bit tells whether the line has already made a round trip out of this level. Lines that have come back are given the oldest-surviving age. Lines arriving for the first time are given a low age, which is either fixed or chosen by an outside policy selector.

Each cycle the block offers a victim way. A fill writes the incoming line into that way. A hit lookup by way number removes the line and reports its stored trip-count bit, so the level above can carry it with the data. When the set is full, every fill first slides all ages down by the current minimum. This keeps their order and leaves room at the top.

Top module: `tc_age_repl`

## Requirements
- R1: After reset every way is invalid, `victim_way` is 0 and `hit_found` is 0 even with `hit_vld` high.
- R2: While any way is invalid, `victim_way` is the lowest-numbered invalid way.
- R3: When every way is valid, `victim_way` is the way with the smallest age, and a tie goes to the lowest-numbered way.
- R4: A fill with `fill_tc`=1 writes the victim way as valid with trip count 1 and age 3.
- R5: A fill with `fill_tc`=0 and `dyn_mode`=0 writes age 1.
- R6: A fill with `fill_tc`=0 and `dyn_mode`=1 writes age 0 when `dyn_zero`=1 and age 1 when `dyn_zero`=0.
- R7: A fill into a full set first lowers the age of every way by the minimum age, which keeps their relative order. A fill into a set that has an invalid way leaves the other ages unchanged.
- R8: A hit on a valid way raises `hit_found` in the same cycle and gives that line's trip count on `hit_tc`. From the next cycle the way is invalid.
- R9: A hit on an invalid way gives `hit_found`=0 and changes no state.
- R10: `fill_vld` and `hit_vld` both high in one cycle raise `collide` in that cycle and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_vld | input | 1 | Write a line into the victim way |
| fill_tc | input | 1 | Trip-count bit of the incoming line |
| dyn_mode | input | 1 | 1 lets `dyn_zero` pick the first-fill age |
| dyn_zero | input | 1 | In dynamic mode, 1 inserts first fills at age 0 |
| hit_vld | input | 1 | Lookup hit on way `hit_way` |
| hit_way | input | $clog2(WAYS) | Way being recalled |
| victim_way | output | $clog2(WAYS) | Way the next fill would replace |
| hit_found | output | 1 | The hit way held a valid line |
| hit_tc | output | 1 | Stored trip count of the recalled line |
| collide | output | 1 | Fill and hit requested together |

## Verification
A fill and a hit can be requested in the same cycle. The bench provokes this on purpose in a directed step, and the random stream also raises both strobes together from time to time. In each such cycle the bench expects `collide` high. It then checks that the next cycle's victim choice and hit responses match a reference model whose state was left unchanged. The checker separately requires that the valid, age and trip-count state stays stable across that edge.

// File: rtl/tc_age_repl.sv
module tc_age_repl #(
  parameter int WAYS = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_vld,
  input  logic             fill_tc,
  input  logic             dyn_mode,
  input  logic             dyn_zero,
  input  logic             hit_vld,
  input  logic [WAY_W-1:0] hit_way,
  output logic [WAY_W-1:0] victim_way,
  output logic             hit_found,
  output logic             hit_tc,
  output logic             collide
);
  logic [WAYS-1:0]      vld_q, tc_q;
  logic [WAYS-1:0][1:0] age_q;
  logic                 inv_any;
  logic [WAY_W-1:0]     inv_idx, min_idx;
  logic [1:0]           min_age, ins_age;
  logic                 do_fill, do_hit;

  always_comb begin
    inv_any = 1'b0;
    inv_idx = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (!vld_q[i]) begin
        inv_any = 1'b1;
        inv_idx = WAY_W'(i);
      end
    min_age = 2'd3;
    min_idx = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (vld_q[i] && age_q[i] <= min_age) begin
        min_age = age_q[i];
        min_idx = WAY_W'(i);
      end
  end

  assign victim_way = inv_any ? inv_idx : min_idx;
  assign ins_age    = fill_tc ? 2'd3 : ((dyn_mode && dyn_zero) ? 2'd0 : 2'd1);
  assign collide    = fill_vld & hit_vld;
  assign do_fill    = fill_vld & ~hit_vld;
  assign do_hit     = hit_vld & ~fill_vld;
  assign hit_found  = do_hit & vld_q[hit_way];
  assign hit_tc     = hit_found & tc_q[hit_way];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      tc_q  <= '0;
      age_q <= '0;
    end else if (do_fill) begin
      if (!inv_any)
        for (int i = 0; i < WAYS; i++) age_q[i] <= age_q[i] - min_age;
      vld_q[victim_way] <= 1'b1;
      tc_q[victim_way]  <= fill_tc;
      age_q[victim_way] <= ins_age;
    end else if (hit_found) begin
      vld_q[hit_way] <= 1'b0;
    end
  end
endmodule

// File: rtl/tc_age_repl_chk.sv
module tc_age_repl_chk #(
  parameter int WAYS = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 fill_vld,
  input logic                 fill_tc,
  input logic                 hit_vld,
  input logic [WAY_W-1:0]     hit_way,
  input logic [WAY_W-1:0]     victim_way,
  input logic [WAYS-1:0]      vld_q,
  input logic [WAYS-1:0]      tc_q,
  input logic [WAYS-1:0][1:0] age_q
);
  a_r2_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
    !(&vld_q) |-> !vld_q[victim_way]);

  a_r4_returning_line_age3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_vld && !hit_vld && fill_tc |=>
      vld_q[$past(victim_way)] && tc_q[$past(victim_way)] && age_q[$past(victim_way)] == 2'd3);

  a_r8_hit_removes: assert property (@(posedge clk) disable iff (!rst_n)
    hit_vld && !fill_vld |=> !vld_q[$past(hit_way)]);

  a_r9_miss_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    hit_vld && !fill_vld && !vld_q[hit_way] |=> $stable(vld_q) && $stable(age_q));

  a_r10_collide_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    fill_vld && hit_vld |=> $stable(vld_q) && $stable(tc_q) && $stable(age_q));
endmodule

bind tc_age_repl tc_age_repl_chk #(.WAYS(WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .fill_vld(fill_vld), .fill_tc(fill_tc),
  .hit_vld(hit_vld), .hit_way(hit_way), .victim_way(victim_way),
  .vld_q(vld_q), .tc_q(tc_q), .age_q(age_q));

// File: tb/tc_age_repl_tb.sv
module tc_age_repl_tb;
  localparam int WAYS = 8;
  localparam int WAY_W = $clog2(WAYS);

  logic clk = 1'b0, rst_n = 1'b0;
  logic fill_vld = 0, fill_tc = 0, dyn_mode = 0, dyn_zero = 0, hit_vld = 0;
  logic [WAY_W-1:0] hit_way = '0;
  logic [WAY_W-1:0] victim_way;
  logic hit_found, hit_tc, collide;

  int checks = 0, errors = 0;
  bit m_vld [WAYS];
  bit m_tc  [WAYS];
  int m_age [WAYS];

  always #5 clk = ~clk;

  tc_age_repl #(.WAYS(WAYS)) u_dut (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int mdl_victim();
    for (int i = 0; i < WAYS; i++) if (!m_vld[i]) return i;
    begin
      int best = 0;
      for (int i = 1; i < WAYS; i++) if (m_age[i] < m_age[best]) best = i;
      return best;
    end
  endfunction

  function automatic bit mdl_full();
    for (int i = 0; i < WAYS; i++) if (!m_vld[i]) return 0;
    return 1;
  endfunction

  task automatic step(string vtag, bit f, bit tc, bit dm, bit dz, bit h, int w);
    int v, mn, ia;
    @(negedge clk);
    fill_vld = f; fill_tc = tc; dyn_mode = dm; dyn_zero = dz;
    hit_vld = h; hit_way = WAY_W'(w);
    #1;
    v = mdl_victim();
    chk(vtag, int'(victim_way), v);
    chk("R10 collide", int'(collide), int'(f && h));
    chk(m_vld[w] ? "R8 hit_found" : "R9 hit_found", int'(hit_found), int'(h && !f && m_vld[w]));
    if (h && !f && m_vld[w]) chk("R8 hit_tc", int'(hit_tc), int'(m_tc[w]));
    @(posedge clk);
    if (f && !h) begin
      if (mdl_full()) begin
        mn = m_age[v];
        for (int i = 0; i < WAYS; i++) m_age[i] -= mn;
      end
      ia = tc ? 3 : ((dm && dz) ? 0 : 1);
      m_vld[v] = 1; m_tc[v] = tc; m_age[v] = ia;
    end else if (h && !f) begin
      m_vld[w] = 0;
    end
  endtask

  function automatic string vt();
    return mdl_full() ? "R3 victim" : "R2 victim";
  endfunction

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < WAYS; i++) begin m_vld[i] = 0; m_tc[i] = 0; m_age[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    hit_vld = 1; hit_way = 3;
    #1;
    chk("R1 victim", int'(victim_way), 0);
    chk("R1 hit_found", int'(hit_found), 0);
    hit_vld = 0;
    rst_n = 1;
    step("R2 victim", 0, 0, 0, 0, 1, 5);
    // fill all ways: ages 3,1,0,1,3,3,3,3
    step("R2 victim", 1, 1, 0, 0, 0, 0);
    step("R2 victim", 1, 0, 0, 0, 0, 0);
    step("R2 victim", 1, 0, 1, 1, 0, 0);
    step("R2 victim", 1, 0, 1, 0, 0, 0);
    for (int i = 4; i < WAYS; i++) step("R2 victim", 1, 1, 0, 0, 0, 0);
    step("R6 victim age0", 0, 0, 0, 0, 0, 0);
    step("R10 victim", 1, 1, 0, 0, 1, 2);
    step("R6 victim after collide", 0, 0, 0, 0, 1, 2);
    step("R2 victim after hit", 1, 0, 0, 0, 0, 0);
    step("R5 R3 tie victim", 1, 1, 0, 0, 0, 0);
    step("R7 victim after slide", 1, 1, 0, 0, 0, 0);
    step("R7 victim", 1, 1, 0, 0, 0, 0);
    step("R7 order kept", 1, 1, 0, 0, 0, 0);
    step("R4 victim", 0, 0, 0, 0, 1, 0);
    step("R9 victim", 0, 0, 0, 0, 1, 0);
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      bit f = (r < 55) || (r >= 95);
      bit h = (r >= 50);
      step(vt(), f, 1'($urandom), 1'($urandom), 1'($urandom), h, $urandom_range(0, WAYS - 1));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule